// File: doc/BRIEF.md
# FIFO Level Flag Generator

This block produces the three level indications of a dual-clock FIFO that holds DEPTH words: an almost-full flag, an almost-empty flag and a half-full flag, all active low. It keeps its own write and read pointers, which advance on each accepted write (`wr_en` at a write-clock edge) and each accepted read (`rd_en` at a read-clock edge). Each pointer crosses to the other clock domain as Gray code through a two-flop synchronizer. The caller asserts `wr_en` only while the FIFO is not full and `rd_en` only while it is not empty.

The almost-full threshold uses a full-side offset and the almost-empty threshold uses an empty-side offset. Both offsets sit in registers that take their default values at reset. The `fwft_mode` input selects fall-through operation, in which the extra output register raises the capacity to DEPTH+1 words. Every threshold then moves by one word. The half-full flag is set from the write domain and cleared from the read domain. Its output is the comparison of two state bits, one owned by each domain, so the flag is asynchronous to both clocks.

Top module: `fifo_level_flags`

## Requirements
- R1: After reset, `almost_full_n` is 1, `almost_empty_n` is 0 and `half_full_n` is 1.
- R2: With `fwft_mode`=0, `almost_full_n` is 0 exactly when the stored count is at least DEPTH minus the full offset. With no reads since reset, it goes to 0 on the write-clock edge of write number DEPTH minus the offset.
- R3: With `fwft_mode`=1, the almost-full threshold is DEPTH+1 minus the full offset.
- R4: `almost_full_n` changes only at write-clock edges. Reads made while the write clock is stopped leave it unchanged until write-clock edges resume.
- R5: With `fwft_mode`=0, `almost_empty_n` is 0 exactly when the stored count is at most the empty offset. It goes to 0 on the read-clock edge that brings the count to that value.
- R6: With `fwft_mode`=1, `almost_empty_n` is 0 exactly when the stored count is at most the empty offset plus one.
- R7: `almost_empty_n` changes only at read-clock edges. Writes made while the read clock is stopped leave it unchanged until read-clock edges resume.
- R8: `half_full_n` goes to 0 on the write-clock edge that raises the count above DEPTH/2 (`fwft_mode`=0) or above DEPTH/2+1 (`fwft_mode`=1).
- R9: `half_full_n` returns to 1 on the read-clock edge whose read brings the count to DEPTH/2 (`fwft_mode`=0) or to DEPTH/2+1 (`fwft_mode`=1).
- R10: `fwft_mode` encoding is 0 for standard and 1 for fall-through. It is held constant outside reset. The capacity is DEPTH words in standard mode and DEPTH+1 words in fall-through mode.
- R11: After reset the full offset and the empty offset both equal 7 (defaults `DEF_FULL_OFS` and `DEF_EMPTY_OFS`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_mode | input | 1 | 0 = standard, 1 = fall-through |
| wr_en | input | 1 | A word is written at this write-clock edge |
| rd_en | input | 1 | A word is read at this read-clock edge |
| almost_full_n | output | 1 | Low when the count reaches the almost-full threshold (write domain) |
| almost_empty_n | output | 1 | Low when the count is at or below the almost-empty limit (read domain) |
| half_full_n | output | 1 | Low while more than half the capacity is stored |

## Verification
With the default depth of 16 and the default offsets, the almost-full threshold and the half-full threshold fall on the same write in both modes: write 9 in standard mode and write 10 in fall-through mode. One write-clock edge must therefore drop two flags driven by separate logic paths, the registered almost-full compare and the half-full set toggle. The bench fills the FIFO one word at a time from reset. It samples both flags half a write period after each write edge and compares them with arithmetic expectations. This shows that the same-cycle set neither delays nor masks either flag. The drain sweep then checks, on the same read edge, that the half-full clear does not disturb the almost-empty flag, and that the clear itself lands on the read the requirement names.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  // words the FIFO can hold: the fall-through output register adds one
  function automatic int cap_words(int depth, logic fwft);
    return depth + (fwft ? 1 : 0);
  endfunction

  // count at or above which almost-full is asserted
  function automatic int af_trip(int depth, logic fwft, int full_ofs);
    return cap_words(depth, fwft) - full_ofs;
  endfunction

  // count at or below which almost-empty is asserted
  function automatic int ae_limit(logic fwft, int empty_ofs);
    return empty_ofs + (fwft ? 1 : 0);
  endfunction

  // half-full is asserted while the count is strictly above this value
  function automatic int hf_limit(int depth, logic fwft);
    return depth / 2 + (fwft ? 1 : 0);
  endfunction
endpackage

// File: rtl/flag_sync2.sv
module flag_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/flag_wr_side.sv
module flag_wr_side
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = 5,
  parameter int OW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          wr_en,
  input  logic [OW-1:0] full_ofs,
  input  logic [PW-1:0] rd_gray_s,
  input  logic          rd_state_s,
  output logic [PW-1:0] wr_gray,
  output logic          wr_state,
  output logic          paf_n
);
  logic [PW-1:0] wptr, wptr_nx, rptr_s, wcnt_nx;
  logic          hf_high_seen, hf_set_go;

  function automatic logic [PW-1:0] gray_to_bin(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign rptr_s       = gray_to_bin(rd_gray_s);
  assign wptr_nx      = wptr + {{(PW-1){1'b0}}, wr_en};
  assign wcnt_nx      = wptr_nx - rptr_s;
  assign hf_high_seen = (wr_state == rd_state_s);
  assign hf_set_go    = hf_high_seen && (int'(wcnt_nx) > hf_limit(DEPTH, fwft));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      wr_gray  <= '0;
      wr_state <= 1'b0;
      paf_n    <= 1'b1;
    end else begin
      wptr    <= wptr_nx;
      wr_gray <= wptr_nx ^ (wptr_nx >> 1);
      paf_n   <= !(int'(wcnt_nx) >= af_trip(DEPTH, fwft, int'(full_ofs)));
      if (hf_set_go) wr_state <= ~wr_state;
    end
  end

  AST_AF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wcnt_nx) == af_trip(DEPTH, fwft, int'(full_ofs))) |=> !paf_n); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wptr - rptr_s) < cap_words(DEPTH, fwft))); // R10
  AST_HF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hf_high_seen && int'(wcnt_nx) == hf_limit(DEPTH, fwft) + 1)
      |=> (wr_state != rd_state_s)); // R8
endmodule

// File: rtl/flag_rd_side.sv
module flag_rd_side
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = 5,
  parameter int OW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          rd_en,
  input  logic [OW-1:0] empty_ofs,
  input  logic [PW-1:0] wr_gray_s,
  input  logic          wr_state_s,
  output logic [PW-1:0] rd_gray,
  output logic          rd_state,
  output logic          pae_n
);
  logic [PW-1:0] rptr, rptr_nx, wptr_s, rcnt_nx;
  logic          hf_low_seen, hf_clr_go;

  function automatic logic [PW-1:0] gray_to_bin(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign wptr_s      = gray_to_bin(wr_gray_s);
  assign rptr_nx     = rptr + {{(PW-1){1'b0}}, rd_en};
  assign rcnt_nx     = wptr_s - rptr_nx;
  assign hf_low_seen = (rd_state != wr_state_s);
  assign hf_clr_go   = hf_low_seen && rd_en && (int'(rcnt_nx) <= hf_limit(DEPTH, fwft));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      rd_gray  <= '0;
      rd_state <= 1'b0;
      pae_n    <= 1'b0;
    end else begin
      rptr    <= rptr_nx;
      rd_gray <= rptr_nx ^ (rptr_nx >> 1);
      pae_n   <= !(int'(rcnt_nx) <= ae_limit(fwft, int'(empty_ofs)));
      if (hf_clr_go) rd_state <= ~rd_state;
    end
  end

  AST_AE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(rcnt_nx) == ae_limit(fwft, int'(empty_ofs))) |=> !pae_n); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rptr != wptr_s)); // R10
  AST_HF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hf_low_seen && rd_en && int'(rcnt_nx) == hf_limit(DEPTH, fwft))
      |=> (rd_state == wr_state_s)); // R9
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int DEPTH         = 16,
  parameter int DEF_FULL_OFS  = 7,
  parameter int DEF_EMPTY_OFS = 7
) (
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic rst_n,
  input  logic fwft_mode,
  input  logic wr_en,
  input  logic rd_en,
  output logic almost_full_n,
  output logic almost_empty_n,
  output logic half_full_n
);
  localparam int PW = $clog2(DEPTH + 2);
  localparam int OW = $clog2(DEPTH + 2);

  logic [OW-1:0] full_ofs_q, empty_ofs_q;
  logic [PW-1:0] wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic          wr_state, rd_state, wr_state_s, rd_state_s;

  // offset registers: defaults are taken at reset, then held
  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) full_ofs_q <= OW'(DEF_FULL_OFS);
    else        full_ofs_q <= full_ofs_q;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) empty_ofs_q <= OW'(DEF_EMPTY_OFS);
    else        empty_ofs_q <= empty_ofs_q;
  end

  // write pointer and half-full set state into the read domain
  flag_sync2 #(.W(PW + 1)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n),
    .d({wr_state, wr_gray}), .q({wr_state_s, wr_gray_s})
  );

  // read pointer and half-full clear state into the write domain
  flag_sync2 #(.W(PW + 1)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n),
    .d({rd_state, rd_gray}), .q({rd_state_s, rd_gray_s})
  );

  flag_wr_side #(.DEPTH(DEPTH), .PW(PW), .OW(OW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .fwft(fwft_mode), .wr_en(wr_en),
    .full_ofs(full_ofs_q), .rd_gray_s(rd_gray_s), .rd_state_s(rd_state_s),
    .wr_gray(wr_gray), .wr_state(wr_state), .paf_n(almost_full_n)
  );

  flag_rd_side #(.DEPTH(DEPTH), .PW(PW), .OW(OW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .fwft(fwft_mode), .rd_en(rd_en),
    .empty_ofs(empty_ofs_q), .wr_gray_s(wr_gray_s), .wr_state_s(wr_state_s),
    .rd_gray(rd_gray), .rd_state(rd_state), .pae_n(almost_empty_n)
  );

  // low while the two domain state bits differ; only one side moves per edge
  assign half_full_n = ~(wr_state ^ rd_state);

  AST_OFS_HELD: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $stable(full_ofs_q)); // R11
endmodule

// File: tb/tb_fifo_level_flags.sv
`timescale 1ns/1ps
module tb_fifo_level_flags;
  localparam int D = 16;
  localparam int M = 7;
  localparam int N = 7;

  logic wclk_src = 0, rclk_src = 0;
  logic wclk_on = 1, rclk_on = 1;
  logic wr_clk, rd_clk;
  logic rst_n = 0, fwft_mode = 0, wr_en = 0, rd_en = 0;
  logic almost_full_n, almost_empty_n, half_full_n;

  int total = 0, bad = 0, cnt = 0;
  bit done = 0;

  always #2   wclk_src = ~wclk_src;  // 250 MHz
  always #3.5 rclk_src = ~rclk_src;
  assign wr_clk = wclk_src & wclk_on;
  assign rd_clk = rclk_src & rclk_on;

  fifo_level_flags #(.DEPTH(D), .DEF_FULL_OFS(M), .DEF_EMPTY_OFS(N)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wr_en(wr_en), .rd_en(rd_en), .almost_full_n(almost_full_n),
    .almost_empty_n(almost_empty_n), .half_full_n(half_full_n)
  );

  function automatic logic exp_af(logic md, int c);
    return md ? !(c + M > D) : !(c + M >= D);
  endfunction
  function automatic logic exp_ae(logic md, int c);
    return !(c < N + 1 + (md ? 1 : 0));
  endfunction
  function automatic logic exp_hf(logic md, int c);
    return !(2 * c > D + (md ? 2 : 0));
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s count=%0d mode=%0b actual=%0b expected=%0b", req, cnt, fwft_mode, act, exp);
    end
  endtask

  task automatic do_write();
    @(negedge wclk_src); wr_en = 1;
    @(negedge wclk_src); wr_en = 0;
    cnt++;
  endtask
  task automatic do_read();
    @(negedge rclk_src); rd_en = 1;
    @(negedge rclk_src); rd_en = 0;
    cnt--;
  endtask
  task automatic settle();
    repeat (6) @(negedge rclk_src);
    repeat (6) @(negedge wclk_src);
  endtask
  task automatic do_reset(logic md);
    @(negedge wclk_src); rst_n = 0; fwft_mode = md; cnt = 0;
    repeat (4) @(negedge rclk_src);
    @(negedge wclk_src); rst_n = 1;
    settle();
  endtask

  initial begin
    for (int md = 0; md < 2; md++) begin
      logic mb;
      mb = md[0];
      do_reset(mb);
      chk("R1 almost_full reset", almost_full_n, 1'b1);
      chk("R1 almost_empty reset", almost_empty_n, 1'b0);
      chk("R1 half_full reset", half_full_n, 1'b1);
      // fill sweep: write-domain flags checked half a period after the write edge
      for (int k = 1; k <= D + md; k++) begin
        do_write();
        chk(mb ? "R3 R11 almost_full on write" : "R2 R11 almost_full on write", almost_full_n, exp_af(mb, cnt));
        chk("R8 half_full on write", half_full_n, exp_hf(mb, cnt));
        settle();
        chk(mb ? "R6 almost_empty level" : "R5 almost_empty level", almost_empty_n, exp_ae(mb, cnt));
        chk("R10 almost_full level", almost_full_n, exp_af(mb, cnt));
      end
      // drain sweep: read-domain flags checked right after the read edge
      for (int k = D + md; k >= 1; k--) begin
        do_read();
        chk(mb ? "R6 R11 almost_empty on read" : "R5 R11 almost_empty on read", almost_empty_n, exp_ae(mb, cnt));
        chk("R9 half_full on read", half_full_n, exp_hf(mb, cnt));
        settle();
        chk(mb ? "R3 almost_full level" : "R2 almost_full level", almost_full_n, exp_af(mb, cnt));
        chk("R10 half_full level", half_full_n, exp_hf(mb, cnt));
      end
    end

    // R4: reads with the write clock stopped leave almost_full untouched
    do_reset(1'b0);
    for (int k = 0; k < D; k++) do_write();
    settle();
    chk("R4 full before stop", almost_full_n, 1'b0);
    @(negedge wclk_src); wclk_on = 0;
    for (int k = 0; k < D; k++) do_read();
    repeat (8) @(negedge rclk_src);
    chk("R4 held while write clock stopped", almost_full_n, 1'b0);
    @(negedge wclk_src); wclk_on = 1;
    repeat (6) @(negedge wclk_src);
    chk("R4 released after write edges", almost_full_n, 1'b1);

    // R7: writes with the read clock stopped leave almost_empty untouched
    do_reset(1'b0);
    @(negedge rclk_src); rclk_on = 0;
    for (int k = 0; k < D; k++) do_write();
    repeat (8) @(negedge wclk_src);
    chk("R7 held while read clock stopped", almost_empty_n, 1'b0);
    @(negedge rclk_src); rclk_on = 1;
    repeat (6) @(negedge rclk_src);
    chk("R7 released after read edges", almost_empty_n, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule